// File: doc/BRIEF.md
# ATA Task-File Register Front End

This block is the device-side register front end of a parallel ATA-style storage target. It watches the host's two active-low chip selects, two active-low byte enables, a 4-bit register offset and the read and write strobes, and works out which register an access reaches and on which byte lane its data travels. Data, error and feature registers share overlapping offsets, so the lane that is used depends on the combination of the two byte enables and the offset.

Data-port writes go into a word queue that the sector-buffer side drains. Data-port reads are served from a second word queue that the sector-buffer side fills. The block holds the error register, which only the internal command engine loads, and the feature register, which only the host writes. It forwards the other task-file offsets to the engine, keeps an interrupt-disable bit from the device control register, and drives the interrupt request and the active-low 16-bit-transfer indication. Host writes take effect on the trailing (low-to-high) edge of the write strobe. The strobes are treated as already synchronous to `clk`.

Top module: `ata_taskfile_if`

## Requirements
- R1: While `rst_n` is low, and right after it, the feature register, error register, interrupt-disable bit and pending interrupt are 0 and both word queues are empty.
- R2: With `cs0_n` low and both byte enables low, offsets 0, 1, 8 and 9 reach the word data port: a write pushes `din[15:0]` into the write queue, and a read returns the read-queue head on D15-D0 and pops it at the end of the read.
- R3: Byte data with only the low enable active: offset 0 or 8 is the even byte on D7-D0, offset 9 is the odd byte on D7-D0. With only the high enable active, offset 8 or 9 is the odd byte on D15-D8. An even write is held. An odd write pushes {odd, held even}. An even read returns head[7:0] without popping. An odd read returns head[15:8] and pops.
- R4: Error/feature lanes: with only the high enable active, offsets 0, 1 and Dh use D15-D8. With only the low enable active, offsets 1 and Dh use D7-D0. A word access at Dh uses D15-D8. A write loads the feature output. A read returns the error register.
- R5: A pulse on `err_load` loads the error register from `err_din`, keeping bits 7, 6, 4, 2 and 0. Bits 5, 3 and 1 always read 0. Host writes never change the error register.
- R6: A host write takes effect only when `wr_n` rises. Data that changes while the strobe is low has no effect; the value present at the rising edge is used.
- R7: Task-file offsets 2 to 7 under `cs0_n` are forwarded: `tf_addr` carries offset[2:0], `tf_we` pulses at the write's trailing edge with `tf_wdata` equal to D7-D0, and a read returns `tf_rdata` on D7-D0.
- R8: With only `cs1_n` low, the low enable active and offset[2:0] = 6, a write sets the interrupt-disable bit from D1 and a read returns `alt_status` on D7-D0.
- R9: A pulse on `irq_set` makes an interrupt pending. `irq` is high while one is pending and the disable bit is 0. A completed `cs0_n` read of offset 7 clears the pending interrupt.
- R10: `iois16_n` is low exactly while `cs0_n` is low, `cs1_n` is high and the offset is 0, 8 or 9.
- R11: `rd_oe` is high only while `rd_n` is low and a chip select is low. `rd_data` is 0 whenever `rd_oe` is low, and an unselected lane reads 0.
- R12: A push into a full queue is dropped. A data read from an empty read queue returns 0 and pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| cs0_n | input | 1 | Task-file chip select, active low |
| cs1_n | input | 1 | Control-block chip select, active low |
| ce_hi_n | input | 1 | Upper byte enable, active low |
| ce_lo_n | input | 1 | Lower byte enable, active low |
| addr | input | 4 | Register offset |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| din | input | 16 | Host write data |
| rd_data | output | 16 | Host read data |
| rd_oe | output | 1 | Read data bus drive enable |
| irq | output | 1 | Interrupt request, active high |
| iois16_n | output | 1 | 16-bit data cycle indication, active low |
| feature | output | 8 | Feature register toward the engine |
| err_load | input | 1 | Engine loads the error register |
| err_din | input | 8 | Error value from the engine |
| irq_set | input | 1 | Engine raises an interrupt |
| alt_status | input | 8 | Status value for control-block reads |
| tf_addr | output | 3 | Task-file offset toward the engine |
| tf_we | output | 1 | Task-file write pulse |
| tf_wdata | output | 8 | Task-file write byte |
| tf_rdata | input | 8 | Task-file read byte from the engine |
| wq_pop | input | 1 | Sector side pops the write queue |
| wq_data | output | 16 | Write queue head |
| wq_empty | output | 1 | Write queue empty |
| rq_push | input | 1 | Sector side pushes the read queue |
| rq_wdata | input | 16 | Word pushed into the read queue |
| rq_full | output | 1 | Read queue full |

## Verification
A wrong lane decode shows on the very read that uses it: the byte appears on the other half of `rd_data`, or the value is 0. A queue pointer that slips shows only one access later, as words leaving `wq_data` in the wrong order or an odd/even pair that is swapped or comes from two different words. That is why the bench drains the queues and compares whole sequences, not single words. A stuck pending-interrupt or disable bit shows on `irq` within one cycle of the event, and a write that commits on the falling strobe edge changes `feature` before `wr_n` rises.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_WORD    = 3'd1,
    ACC_EVEN    = 3'd2,
    ACC_ODD     = 3'd3,
    ACC_ERRFEAT = 3'd4,
    ACC_TASK    = 3'd5,
    ACC_DEVCTL  = 3'd6
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e kind;
    logic      hi_lane;
  } acc_t;

  // Implemented error bits: 7, 6, 4, 2, 0
  localparam logic [7:0] ERR_MASK   = 8'hD5;
  localparam logic [2:0] DEVCTL_OFS = 3'd6;
  localparam logic [2:0] STATUS_OFS = 3'd7;
  localparam int         NIEN_BIT   = 1;

  // Which register and lane an access reaches
  function automatic acc_t decode_access(input logic cs0_n, input logic cs1_n,
                                         input logic hi_n, input logic lo_n,
                                         input logic [3:0] ofs);
    acc_t r;
    r.kind    = ACC_NONE;
    r.hi_lane = 1'b0;
    if (!cs0_n && cs1_n) begin
      if (!hi_n && !lo_n) begin
        if (ofs == 4'h0 || ofs == 4'h1 || ofs == 4'h8 || ofs == 4'h9)
          r.kind = ACC_WORD;
        else if (ofs == 4'hD) begin
          r.kind    = ACC_ERRFEAT;
          r.hi_lane = 1'b1;
        end else if (ofs >= 4'h2 && ofs <= 4'h7)
          r.kind = ACC_TASK;
      end else if (!lo_n) begin
        if (ofs == 4'h0 || ofs == 4'h8)      r.kind = ACC_EVEN;
        else if (ofs == 4'h9)                r.kind = ACC_ODD;
        else if (ofs == 4'h1 || ofs == 4'hD) r.kind = ACC_ERRFEAT;
        else if (ofs >= 4'h2 && ofs <= 4'h7) r.kind = ACC_TASK;
      end else if (!hi_n) begin
        r.hi_lane = 1'b1;
        if (ofs == 4'h8 || ofs == 4'h9)
          r.kind = ACC_ODD;
        else if (ofs == 4'h0 || ofs == 4'h1 || ofs == 4'hD)
          r.kind = ACC_ERRFEAT;
      end
    end else if (cs0_n && !cs1_n && !lo_n && ofs[2:0] == DEVCTL_OFS) begin
      r.kind = ACC_DEVCTL;
    end
    return r;
  endfunction

  function automatic logic [15:0] place_byte(input logic [7:0] b, input logic hi);
    return hi ? {b, 8'h00} : {8'h00, b};
  endfunction

  function automatic logic [7:0] pick_byte(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

  function automatic logic is_word_port(input logic cs0_n, input logic cs1_n,
                                        input logic [3:0] ofs);
    return !cs0_n && cs1_n && (ofs == 4'h0 || ofs == 4'h8 || ofs == 4'h9);
  endfunction

endpackage

// File: rtl/ata_tf_fifo.sv
module ata_tf_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ata_tf_strobe.sv
module ata_tf_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  input  logic rd_n,
  output logic wr_evt,
  output logic rd_evt
);
  logic wr_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  // trailing (low-to-high) strobe edges
  assign wr_evt = !wr_q && wr_n;
  assign rd_evt = !rd_q && rd_n;
endmodule

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
(
  input  logic       cs0_n,
  input  logic       cs1_n,
  input  logic       ce_hi_n,
  input  logic       ce_lo_n,
  input  logic [3:0] addr,
  output acc_t       acc,
  output logic       word_port
);
  assign acc       = decode_access(cs0_n, cs1_n, ce_hi_n, ce_lo_n, addr);
  assign word_port = is_word_port(cs0_n, cs1_n, addr);
endmodule

// File: rtl/ata_taskfile_if.sv
module ata_taskfile_if
  import ata_tf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs0_n,
  input  logic        cs1_n,
  input  logic        ce_hi_n,
  input  logic        ce_lo_n,
  input  logic [3:0]  addr,
  input  logic        wr_n,
  input  logic        rd_n,
  input  logic [15:0] din,
  output logic [15:0] rd_data,
  output logic        rd_oe,
  output logic        irq,
  output logic        iois16_n,
  output logic [7:0]  feature,
  input  logic        err_load,
  input  logic [7:0]  err_din,
  input  logic        irq_set,
  input  logic [7:0]  alt_status,
  output logic [2:0]  tf_addr,
  output logic        tf_we,
  output logic [7:0]  tf_wdata,
  input  logic [7:0]  tf_rdata,
  input  logic        wq_pop,
  output logic [15:0] wq_data,
  output logic        wq_empty,
  input  logic        rq_push,
  input  logic [15:0] rq_wdata,
  output logic        rq_full
);
  localparam int WORD_W = 16;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  acc_t              acc;
  logic              word_port;
  logic              wr_evt, rd_evt;
  logic [7:0]        lane_in;
  logic [7:0]        even_hold;
  logic [7:0]        err_q;
  logic              nien_q;
  logic              irq_pend;
  logic              wq_push, wq_full;
  logic [WORD_W-1:0] wq_wdata;
  logic              rq_pop, rq_empty;
  logic [WORD_W-1:0] rq_rdata, rq_head;
  logic [CNT_W-1:0]  wq_count, rq_count;
  logic [WORD_W-1:0] rd_value;
  logic              status_read;

  ata_tf_decode u_decode (
    .cs0_n(cs0_n), .cs1_n(cs1_n), .ce_hi_n(ce_hi_n), .ce_lo_n(ce_lo_n),
    .addr(addr), .acc(acc), .word_port(word_port)
  );

  ata_tf_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
    .wr_evt(wr_evt), .rd_evt(rd_evt)
  );

  assign lane_in = pick_byte(din, acc.hi_lane);

  // host -> sector buffer
  assign wq_push  = wr_evt && !wq_full && (acc.kind == ACC_WORD || acc.kind == ACC_ODD);
  assign wq_wdata = (acc.kind == ACC_WORD) ? din : {lane_in, even_hold};

  ata_tf_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_n), .push(wq_push), .wdata(wq_wdata),
    .pop(wq_pop), .rdata(wq_data), .full(wq_full), .empty(wq_empty),
    .count(wq_count)
  );

  // sector buffer -> host
  assign rq_pop  = rd_evt && (acc.kind == ACC_WORD || acc.kind == ACC_ODD);
  assign rq_head = rq_empty ? '0 : rq_rdata;

  ata_tf_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_n), .push(rq_push), .wdata(rq_wdata),
    .pop(rq_pop), .rdata(rq_rdata), .full(rq_full), .empty(rq_empty),
    .count(rq_count)
  );

  // registers written by the host or the engine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_hold <= '0;
      feature   <= '0;
      err_q     <= '0;
      nien_q    <= 1'b0;
    end else begin
      if (wr_evt && acc.kind == ACC_EVEN)    even_hold <= lane_in;
      if (wr_evt && acc.kind == ACC_ERRFEAT) feature   <= lane_in;
      if (wr_evt && acc.kind == ACC_DEVCTL)  nien_q    <= lane_in[NIEN_BIT];
      if (err_load)                          err_q     <= err_din & ERR_MASK;
    end
  end

  assign status_read = rd_evt && acc.kind == ACC_TASK && addr[2:0] == STATUS_OFS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           irq_pend <= 1'b0;
    else if (irq_set)     irq_pend <= 1'b1;
    else if (status_read) irq_pend <= 1'b0;
  end

  assign irq      = irq_pend && !nien_q;
  assign iois16_n = !word_port;

  // task-file pass-through to the engine
  assign tf_addr  = addr[2:0];
  assign tf_we    = wr_evt && acc.kind == ACC_TASK;
  assign tf_wdata = lane_in;

  // read path
  always_comb begin
    case (acc.kind)
      ACC_WORD:    rd_value = rq_head;
      ACC_EVEN:    rd_value = place_byte(rq_head[7:0], 1'b0);
      ACC_ODD:     rd_value = place_byte(rq_head[15:8], acc.hi_lane);
      ACC_ERRFEAT: rd_value = place_byte(err_q, acc.hi_lane);
      ACC_TASK:    rd_value = place_byte(tf_rdata, 1'b0);
      ACC_DEVCTL:  rd_value = place_byte(alt_status, 1'b0);
      default:     rd_value = '0;
    endcase
  end

  assign rd_oe   = !rd_n && (!cs0_n || !cs1_n);
  assign rd_data = rd_oe ? rd_value : '0;

endmodule

// File: rtl/ata_taskfile_if_chk.sv
module ata_taskfile_if_chk
  import ata_tf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_n,
  input logic             rd_oe,
  input logic             wr_evt,
  input logic             rd_evt,
  input acc_kind_e        acc_kind,
  input logic [CNT_W-1:0] wq_count,
  input logic [CNT_W-1:0] rq_count,
  input logic             wq_pop,
  input logic             rq_push,
  input logic [7:0]       err_q,
  input logic [7:0]       feature,
  input logic             nien_q,
  input logic             irq_set,
  input logic             irq
);
  assert_err_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q & 8'h2A) == 8'h00);

  assert_word_write_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && acc_kind == ACC_WORD && wq_count < CNT_W'(DEPTH) && !wq_pop)
    |=> wq_count == CNT_W'($past(wq_count) + 1'b1));

  assert_odd_read_pops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && acc_kind == ACC_ODD && rq_count != '0 && !rq_push)
    |=> rq_count == CNT_W'($past(rq_count) - 1'b1));

  assert_even_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && acc_kind == ACC_EVEN && !rq_push) |=> $stable(rq_count));

  assert_feature_on_trailing_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> $stable(feature));

  assert_irq_follows_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set && !nien_q && !(wr_evt && acc_kind == ACC_DEVCTL)) |=> irq);

  assert_oe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> !rd_oe);

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wq_count <= CNT_W'(DEPTH) && rq_count <= CNT_W'(DEPTH));
endmodule

bind ata_taskfile_if ata_taskfile_if_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_oe(rd_oe),
  .wr_evt(wr_evt), .rd_evt(rd_evt), .acc_kind(acc.kind),
  .wq_count(wq_count), .rq_count(rq_count), .wq_pop(wq_pop),
  .rq_push(rq_push), .err_q(err_q), .feature(feature),
  .nien_q(nien_q), .irq_set(irq_set), .irq(irq)
);

// File: tb/ata_taskfile_if_test.sv
module ata_taskfile_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs0_n = 1'b1, cs1_n = 1'b1, ce_hi_n = 1'b1, ce_lo_n = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_n = 1'b1, rd_n = 1'b1;
  logic [15:0] din = '0;
  logic [15:0] rd_data;
  logic        rd_oe, irq, iois16_n;
  logic [7:0]  feature;
  logic        err_load = 1'b0;
  logic [7:0]  err_din = '0;
  logic        irq_set = 1'b0;
  logic [7:0]  alt_status = 8'h50;
  logic [2:0]  tf_addr;
  logic        tf_we;
  logic [7:0]  tf_wdata;
  logic [7:0]  tf_rdata = 8'h81;
  logic        wq_pop = 1'b0;
  logic [15:0] wq_data;
  logic        wq_empty;
  logic        rq_push = 1'b0;
  logic [15:0] rq_wdata = '0;
  logic        rq_full;

  int checks = 0;
  int errors = 0;
  logic        seen_we;
  logic [2:0]  seen_addr;
  logic [7:0]  seen_wdata;
  logic [15:0] rv;
  logic        roe;

  ata_taskfile_if #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n),
    .ce_hi_n(ce_hi_n), .ce_lo_n(ce_lo_n), .addr(addr), .wr_n(wr_n),
    .rd_n(rd_n), .din(din), .rd_data(rd_data), .rd_oe(rd_oe), .irq(irq),
    .iois16_n(iois16_n), .feature(feature), .err_load(err_load),
    .err_din(err_din), .irq_set(irq_set), .alt_status(alt_status),
    .tf_addr(tf_addr), .tf_we(tf_we), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata), .wq_pop(wq_pop), .wq_data(wq_data),
    .wq_empty(wq_empty), .rq_push(rq_push), .rq_wdata(rq_wdata),
    .rq_full(rq_full)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic idle();
    cs0_n = 1'b1; cs1_n = 1'b1; ce_hi_n = 1'b1; ce_lo_n = 1'b1;
    wr_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic host_wr(input logic c0, input logic c1, input logic hn, input logic ln,
                         input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cs0_n = c0; cs1_n = c1; ce_hi_n = hn; ce_lo_n = ln; addr = a; din = d;
    wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1;
    #1;
    seen_we = tf_we; seen_addr = tf_addr; seen_wdata = tf_wdata;
    @(negedge clk);
    idle();
  endtask

  task automatic host_rd(input logic c0, input logic c1, input logic hn, input logic ln,
                         input logic [3:0] a);
    @(negedge clk);
    cs0_n = c0; cs1_n = c1; ce_hi_n = hn; ce_lo_n = ln; addr = a;
    rd_n = 1'b0;
    @(negedge clk);
    #1;
    rv = rd_data; roe = rd_oe; seen_addr = tf_addr;
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    idle();
  endtask

  task automatic eng_push(input logic [15:0] d);
    @(negedge clk);
    rq_push = 1'b1; rq_wdata = d;
    @(negedge clk);
    rq_push = 1'b0;
  endtask

  task automatic wq_expect(input string tag, input logic [15:0] d);
    @(negedge clk);
    chk({tag, " queue not empty"}, {15'd0, wq_empty}, 16'd0);
    chk({tag, " queue word"}, wq_data, d);
    wq_pop = 1'b1;
    @(negedge clk);
    wq_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 feature", {8'd0, feature}, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 wq empty", {15'd0, wq_empty}, 16'd1);
    chk("R1 rq not full", {15'd0, rq_full}, 16'd0);
    host_rd(1'b0, 1'b1, 1'b0, 1'b1, 4'h0);
    chk("R1 error reads 0", rv, 16'h0000);
  endtask

  task automatic t_oe_and_iois();
    @(negedge clk);
    rd_n = 1'b0;
    #1;
    chk("R11 no chip select", {15'd0, rd_oe}, 16'd0);
    chk("R11 data zero", rd_data, 16'h0000);
    rd_n = 1'b1; cs0_n = 1'b0; addr = 4'h0;
    #1;
    chk("R11 no strobe", {15'd0, rd_oe}, 16'd0);
    chk("R10 offset 0", {15'd0, iois16_n}, 16'd0);
    addr = 4'h9;
    #1;
    chk("R10 offset 9", {15'd0, iois16_n}, 16'd0);
    addr = 4'h2;
    #1;
    chk("R10 offset 2", {15'd0, iois16_n}, 16'd1);
    cs0_n = 1'b1; cs1_n = 1'b0; addr = 4'h0;
    #1;
    chk("R10 second select", {15'd0, iois16_n}, 16'd1);
    idle();
  endtask

  task automatic t_word_data();
    host_wr(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 16'hA55A);
    host_wr(1'b0, 1'b1, 1'b0, 1'b0, 4'h8, 16'h1234);
    host_wr(1'b0, 1'b1, 1'b0, 1'b0, 4'h1, 16'hBEEF);
    wq_expect("R2 w0", 16'hA55A);
    wq_expect("R2 w8", 16'h1234);
    wq_expect("R2 w1", 16'hBEEF);
    eng_push(16'h1111); eng_push(16'h2222); eng_push(16'h3333);
    host_rd(1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
    chk("R2 read off0", rv, 16'h1111);
    chk("R11 oe during read", {15'd0, roe}, 16'd1);
    host_rd(1'b0, 1'b1, 1'b0, 1'b0, 4'h9);
    chk("R2 read off9", rv, 16'h2222);
    host_rd(1'b0, 1'b1, 1'b0, 1'b0, 4'h1);
    chk("R2 read off1", rv, 16'h3333);
    host_rd(1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
    chk("R12 empty read", rv, 16'h0000);
  endtask

  task automatic t_byte_data();
    host_wr(1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 16'h0034);
    host_wr(1'b0, 1'b1, 1'b1, 1'b0, 4'h9, 16'h0012);
    host_wr(1'b0, 1'b1, 1'b1, 1'b0, 4'h8, 16'h0078);
    host_wr(1'b0, 1'b1, 1'b0, 1'b1, 4'h8, 16'h5600);
    wq_expect("R3 lo odd", 16'h1234);
    wq_expect("R3 hi odd", 16'h5678);
    eng_push(16'hCAFE);
    host_rd(1'b0, 1'b1, 1'b1, 1'b0, 4'h0);
    chk("R3 even read", rv, 16'h00FE);
    host_rd(1'b0, 1'b1, 1'b1, 1'b0, 4'h8);
    chk("R3 even read no pop", rv, 16'h00FE);
    host_rd(1'b0, 1'b1, 1'b0, 1'b1, 4'h9);
    chk("R3 odd read hi lane", rv, 16'hCA00);
    host_rd(1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
    chk("R3 odd read popped", rv, 16'h0000);
    eng_push(16'hBEEF);
    host_rd(1'b0, 1'b1, 1'b1, 1'b0, 4'h9);
    chk("R3 odd read lo lane", rv, 16'h00BE);
    host_rd(1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
    chk("R3 lo odd popped", rv, 16'h0000);
  endtask

  task automatic t_err_feature();
    @(negedge clk);
    err_load = 1'b1; err_din = 8'hFF;
    @(negedge clk);
    err_load = 1'b0;
    host_rd(1'b0, 1'b1, 1'b0, 1'b1, 4'h0);
    chk("R5 R4 error hi off0", rv, 16'hD500);
    host_rd(1'b0, 1'b1, 1'b1, 1'b0, 4'h1);
    chk("R4 error lo off1", rv, 16'h00D5);
    host_rd(1'b0, 1'b1, 1'b1, 1'b0, 4'hD);
    chk("R4 error lo offD", rv, 16'h00D5);
    host_rd(1'b0, 1'b1, 1'b0, 1'b0, 4'hD);
    chk("R4 error word offD", rv, 16'hD500);
    host_wr(1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 16'h9A00);
    chk("R4 feature hi off0", {8'd0, feature}, 16'h009A);
    host_wr(1'b0, 1'b1, 1'b0, 1'b0, 4'hD, 16'hE100);
    chk("R4 feature word offD", {8'd0, feature}, 16'h00E1);
    host_wr(1'b0, 1'b1, 1'b1, 1'b0, 4'h1, 16'h003C);
    chk("R4 feature lo off1", {8'd0, feature}, 16'h003C);
    host_rd(1'b0, 1'b1, 1'b1, 1'b0, 4'h1);
    chk("R5 host write leaves error", rv, 16'h00D5);
    @(negedge clk);
    err_load = 1'b1; err_din = 8'h2A;
    @(negedge clk);
    err_load = 1'b0;
    host_rd(1'b0, 1'b1, 1'b1, 1'b0, 4'h1);
    chk("R5 reserved bits zero", rv, 16'h0000);
  endtask

  task automatic t_trailing_edge();
    @(negedge clk);
    cs0_n = 1'b0; ce_lo_n = 1'b0; addr = 4'h1; din = 16'h0077; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 no change while low", {8'd0, feature}, 16'h003C);
    din = 16'h0066;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    chk("R6 value at trailing edge", {8'd0, feature}, 16'h0066);
    idle();
  endtask

  task automatic t_taskfile();
    host_wr(1'b0, 1'b1, 1'b1, 1'b0, 4'h3, 16'h005C);
    chk("R7 tf_we", {15'd0, seen_we}, 16'd1);
    chk("R7 tf_addr write", {13'd0, seen_addr}, 16'd3);
    chk("R7 tf_wdata", {8'd0, seen_wdata}, 16'h005C);
    host_rd(1'b0, 1'b1, 1'b1, 1'b0, 4'h4);
    chk("R7 tf read data", rv, 16'h0081);
    chk("R7 tf_addr read", {13'd0, seen_addr}, 16'd4);
  endtask

  task automatic t_irq_devctl();
    @(negedge clk);
    irq_set = 1'b1;
    @(negedge clk);
    irq_set = 1'b0;
    chk("R9 irq raised", {15'd0, irq}, 16'd1);
    host_wr(1'b1, 1'b0, 1'b1, 1'b0, 4'h6, 16'h0002);
    chk("R8 disable masks irq", {15'd0, irq}, 16'd0);
    host_rd(1'b1, 1'b0, 1'b1, 1'b0, 4'h6);
    chk("R8 alt status", rv, 16'h0050);
    host_wr(1'b1, 1'b0, 1'b1, 1'b0, 4'h6, 16'h0000);
    chk("R8 enable shows irq", {15'd0, irq}, 16'd1);
    host_rd(1'b0, 1'b1, 1'b1, 1'b0, 4'h5);
    chk("R9 other read keeps irq", {15'd0, irq}, 16'd1);
    host_rd(1'b0, 1'b1, 1'b1, 1'b0, 4'h7);
    chk("R9 status read clears", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_queue_limits();
    for (int i = 0; i <= DEPTH; i++)
      host_wr(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 16'h0100 + 16'(i));
    for (int i = 0; i < DEPTH; i++)
      wq_expect("R12 full write queue", 16'h0100 + 16'(i));
    @(negedge clk);
    chk("R12 extra push dropped", {15'd0, wq_empty}, 16'd1);
    for (int i = 0; i <= DEPTH; i++) eng_push(16'h0200 + 16'(i));
    chk("R12 rq full", {15'd0, rq_full}, 16'd1);
    for (int i = 0; i < DEPTH; i++) begin
      host_rd(1'b0, 1'b1, 1'b0, 1'b0, 4'h8);
      chk("R12 read order", rv, 16'h0200 + 16'(i));
    end
    host_rd(1'b0, 1'b1, 1'b0, 1'b0, 4'h8);
    chk("R12 drained", rv, 16'h0000);
  endtask

  task automatic t_mid_reset();
    host_wr(1'b0, 1'b1, 1'b1, 1'b0, 4'h1, 16'h00AB);
    host_wr(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 16'h4444);
    @(negedge clk);
    irq_set = 1'b1;
    @(negedge clk);
    irq_set = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 feature cleared", {8'd0, feature}, 16'd0);
    chk("R1 irq cleared", {15'd0, irq}, 16'd0);
    chk("R1 wq cleared", {15'd0, wq_empty}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oe_and_iois();
    t_word_data();
    t_byte_data();
    t_err_feature();
    t_trailing_edge();
    t_taskfile();
    t_irq_devctl();
    t_queue_limits();
    t_mid_reset();
    report();
  end
endmodule